// File: doc/BRIEF.md
# Latching Input Transition Detector

This block watches a byte of open-drain port pins that are used as inputs. It keeps a snapshot of the pin levels taken at the last qualifying bus access. Every pin whose live level differs from that snapshot, even for a single clock, sets a sticky change flag. Any such change pulls an active-low, latched interrupt line low. It does not matter whether the pin later returns to its old level.

A bus protocol engine drives the block through four strobes and levels:

- a capture strobe, fired during the acknowledge of the slave address (and of later port bytes in a multibyte read);
- a transaction-active level;
- a STOP strobe;
- a per-pin mask of the pins the device itself is currently driving low.

On capture the snapshot reloads, the flags clear and the interrupt releases. The flags as they stood just before the capture are kept, so the engine can return them as the second data byte of a read.

From the capture until the following STOP the interrupt cannot assert again. A change that arrives inside that window is remembered and raises the interrupt when STOP occurs. Pin movements caused by the device's own output drive never count as changes. All outputs are registered, so an input applied before a clock edge appears on the outputs after that edge.

Top module: `tdet_top`

## Requirements
- R1: A pin that is not excluded by R7 and whose level differs from its snapshot bit sets its flag in `chg_flags` one clock later. The flag stays set until the next capture, even if the pin returns to its snapshot level.
- R2: Outside a capture-to-STOP window, a new change drives `irq_n` low one clock later. `irq_n` stays low until the next capture, and it is low whenever any flag is set outside such a window.
- R3: A capture (`capture` high while `xact_active` is high) loads `pin_in` into `snapshot`, clears every bit of `chg_flags` and drives `irq_n` high, all visible one clock later.
- R4: On a capture, `prior_flags` takes the value `chg_flags` held just before the capture. It keeps that value until the next capture.
- R5: From a capture until the next STOP strobe, `irq_n` stays high whatever the pins do. A further capture inside the window repeats R3 and R4.
- R6: When `stop_strobe` fires, `irq_n` goes low one clock later if any change was detected since the first capture of the window. Otherwise it stays high, and the window ends.
- R7: A pin whose `self_drive` bit is 1 in the current clock or the previous one is excluded from detection. Its snapshot bit follows the pin, and it cannot set a flag or the interrupt.
- R8: `capture` while `xact_active` is low has no effect on any output.
- R9: `xact_active` falling without a STOP strobe, as when the bus interface is reset, leaves `irq_n` and the window unchanged.
- R10: While `rst_n` is low: `chg_flags` and `prior_flags` are 0, `snapshot` equals parameter `SNAP_INIT` (all ones by default), and `irq_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pin_in | input | PORT_W | Pin levels, already synchronized |
| self_drive | input | PORT_W | 1 = the device drives this pin low |
| capture | input | 1 | Snapshot/clear strobe from the protocol engine |
| xact_active | input | 1 | High while a bus transaction addresses the I/O group |
| stop_strobe | input | 1 | One-clock pulse on a bus STOP condition |
| chg_flags | output | PORT_W | Live sticky change flags |
| prior_flags | output | PORT_W | Flags as they stood before the last capture |
| snapshot | output | PORT_W | Snapshot register |
| irq_n | output | 1 | Latched interrupt, active low |

## Verification
The assertions take for granted that `capture` and `stop_strobe` never fire in the same clock. They also assume a STOP eventually closes every window that a capture opens, and that `pin_in` has already been synchronized to `clk`.

The stimulus drives every input on the falling clock edge. It issues captures only inside a raised `xact_active`, except for the single deliberate stray capture. It never overlaps a capture with a STOP. Self-driven pins are moved in the same clock as their mask bit, so that the exclusion window of R7 covers them.

// File: rtl/tdet_pkg.sv
package tdet_pkg;
    // Interrupt sequencing state: interrupt active, window open, late change seen
    typedef struct packed {
        logic irq;
        logic hold;
        logic late;
    } irq_st_t;
endpackage

// File: rtl/tdet_mask.sv
module tdet_mask #(
    parameter int PORT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] self_drive,
    input  logic [PORT_W-1:0] snap_q,
    output logic [PORT_W-1:0] diff,
    output logic [PORT_W-1:0] excl
);
    logic [PORT_W-1:0] mask_prev_d, mask_prev_q;

    always_comb begin
        mask_prev_d = self_drive;
        excl        = self_drive | mask_prev_q;
        diff        = (pin_in ^ snap_q) & ~excl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_prev_q <= '0;
        else        mask_prev_q <= mask_prev_d;
    end
endmodule

// File: rtl/tdet_irq.sv
module tdet_irq
    import tdet_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_fire,
    input  logic stop_strobe,
    input  logic change_any,
    input  logic flag_any,
    output logic irq_active,
    output logic window
);
    irq_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cap_fire) begin
            s_d.irq  = 1'b0;
            s_d.hold = 1'b1;
            s_d.late = s_q.hold ? (s_q.late | change_any) : 1'b0;
        end else if (stop_strobe) begin
            s_d.hold = 1'b0;
            s_d.late = 1'b0;
            s_d.irq  = s_q.irq | s_q.late | change_any;
        end else if (s_q.hold) begin
            s_d.late = s_q.late | change_any;
        end else begin
            s_d.irq  = s_q.irq | change_any;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign irq_active = s_q.irq;
    assign window     = s_q.hold;

    // R2: a flag outside a window always has the interrupt asserted
    p_flag_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.hold && flag_any) |-> s_q.irq);
    // R5: interrupt quiet while the window is open
    p_hold_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.hold |-> !s_q.irq);
    // R6: a late change raises the interrupt at STOP
    p_stop_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_strobe && !cap_fire && s_q.late) |=> s_q.irq);
endmodule

// File: rtl/tdet_top.sv
module tdet_top #(
    parameter int          PORT_W    = 8,
    parameter logic [PORT_W-1:0] SNAP_INIT = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] pin_in,
    input  logic [PORT_W-1:0] self_drive,
    input  logic              capture,
    input  logic              xact_active,
    input  logic              stop_strobe,
    output logic [PORT_W-1:0] chg_flags,
    output logic [PORT_W-1:0] prior_flags,
    output logic [PORT_W-1:0] snapshot,
    output logic              irq_n
);
    typedef struct packed {
        logic [PORT_W-1:0] snap;
        logic [PORT_W-1:0] flag;
        logic [PORT_W-1:0] prior;
    } det_st_t;

    det_st_t st_d, st_q;
    logic [PORT_W-1:0] diff, excl;
    logic cap_fire, irq_active, window;

    assign cap_fire = capture & xact_active;

    tdet_mask #(.PORT_W(PORT_W)) u_mask (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .self_drive (self_drive),
        .snap_q     (st_q.snap),
        .diff       (diff),
        .excl       (excl)
    );

    tdet_irq u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_fire    (cap_fire),
        .stop_strobe (stop_strobe),
        .change_any  (|diff),
        .flag_any    (|st_q.flag),
        .irq_active  (irq_active),
        .window      (window)
    );

    always_comb begin
        st_d = st_q;
        if (cap_fire) begin
            st_d.snap  = pin_in;
            st_d.flag  = '0;
            st_d.prior = st_q.flag;
        end else begin
            st_d.flag = st_q.flag | diff;
            st_d.snap = (st_q.snap & ~excl) | (pin_in & excl);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.snap  <= SNAP_INIT;
            st_q.flag  <= '0;
            st_q.prior <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_flags   = st_q.flag;
    assign prior_flags = st_q.prior;
    assign snapshot    = st_q.snap;
    assign irq_n       = ~irq_active;

    // R1: flags are sticky between captures
    p_flag_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> ((st_q.flag & $past(st_q.flag)) == $past(st_q.flag)));
    // R3: capture loads pins, clears flags, releases interrupt
    p_capture_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (st_q.snap == $past(pin_in) && st_q.flag == '0 && irq_n));
    // R4: prior flags preserved across capture
    p_prior_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> (st_q.prior == $past(st_q.flag)));
    // R7: self-driven pins never gain a flag
    p_mask_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fire |=> ((st_q.flag & $past(self_drive)) == ($past(st_q.flag) & $past(self_drive))));
    // R8: stray capture leaves prior flags alone
    p_stray_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !xact_active) |=> $stable(st_q.prior));
    // R9: losing the transaction without STOP keeps the window
    p_abort_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (window && !xact_active && !stop_strobe && !cap_fire) |=> window);
endmodule

// File: tb/tb_tdet_top.sv
module tb_tdet_top;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [W-1:0] pin_in = 8'hFF;
    logic [W-1:0] self_drive = '0;
    logic capture = 1'b0, xact_active = 1'b0, stop_strobe = 1'b0;
    logic [W-1:0] chg_flags, prior_flags, snapshot;
    logic irq_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    tdet_top #(.PORT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .self_drive(self_drive),
        .capture(capture), .xact_active(xact_active), .stop_strobe(stop_strobe),
        .chg_flags(chg_flags), .prior_flags(prior_flags), .snapshot(snapshot),
        .irq_n(irq_n)
    );

    typedef struct packed {
        logic [7:0] pins;
        logic [7:0] mask;
        logic       cap;
        logic       xact;
        logic       stop;
        logic [7:0] e_flag;
        logic [7:0] e_prior;
        logic [7:0] e_snap;
        logic       e_irqn;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b1, 4'd10}, // R10 idle
        '{8'hFE, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 8'hFF, 1'b0, 4'd1 }, // R1 change
        '{8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 8'hFF, 1'b0, 4'd1 }, // R1 sticky
        '{8'hFF, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h01, 8'hFF, 1'b1, 4'd3 }, // R3 capture
        '{8'hF7, 8'h00, 1'b0, 1'b1, 1'b0, 8'h08, 8'h01, 8'hFF, 1'b1, 4'd5 }, // R5 held off
        '{8'hF7, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h08, 8'hF7, 1'b1, 4'd4 }, // R4 recapture
        '{8'hF7, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h08, 8'hF7, 1'b0, 4'd6 }, // R6 late change
        '{8'hF7, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h08, 8'hF7, 1'b0, 4'd2 }, // R2 latched
        '{8'hF7, 8'h00, 1'b1, 1'b0, 1'b0, 8'h00, 8'h08, 8'hF7, 1'b0, 4'd8 }, // R8 stray
        '{8'hF7, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 8'hF7, 1'b1, 4'd3 }, // R3 clean
        '{8'hF7, 8'h00, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 8'hF7, 1'b1, 4'd6 }, // R6 quiet stop
        '{8'hE7, 8'h10, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hE7, 1'b1, 4'd7 }, // R7 drive low
        '{8'hF7, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hF7, 1'b1, 4'd7 }, // R7 release
        '{8'hF7, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 8'hF7, 1'b1, 4'd7 }, // R7 settled
        '{8'h77, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 8'hF7, 1'b0, 4'd1 }, // R1 bit 7
        '{8'h77, 8'h00, 1'b0, 1'b1, 1'b0, 8'h80, 8'h00, 8'hF7, 1'b0, 4'd2 }, // R2 no capture
        '{8'h77, 8'h00, 1'b0, 1'b0, 1'b0, 8'h80, 8'h00, 8'hF7, 1'b0, 4'd9 }, // R9 abort
        '{8'h77, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00, 8'h80, 8'h77, 1'b1, 4'd3 }, // R3 open
        '{8'h77, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80, 8'h77, 1'b1, 4'd9 }, // R9 abort in window
        '{8'h76, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h80, 8'h77, 1'b1, 4'd5 }, // R5 still held
        '{8'h76, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 8'h80, 8'h77, 1'b0, 4'd6 }, // R6 late stop
        '{8'h76, 8'h00, 1'b0, 1'b0, 1'b0, 8'h01, 8'h80, 8'h77, 1'b0, 4'd2 }  // R2 stays low
    };

    task automatic check_all(input int req, input logic [7:0] ef, input logic [7:0] ep,
                             input logic [7:0] es, input logic ei);
        n_chk++;
        if (chg_flags !== ef || prior_flags !== ep || snapshot !== es || irq_n !== ei) begin
            n_fail++;
            $display("FAIL R%0d: flags/prior/snap/irq_n = %h/%h/%h/%b expected %h/%h/%h/%b",
                     req, chg_flags, prior_flags, snapshot, irq_n, ef, ep, es, ei);
        end
    endtask

    initial begin
        #20000;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R10: reset state
        @(negedge clk);
        check_all(10, 8'h00, 8'h00, 8'hFF, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            pin_in = VECS[i].pins;
            self_drive = VECS[i].mask;
            capture = VECS[i].cap;
            xact_active = VECS[i].xact;
            stop_strobe = VECS[i].stop;
            @(negedge clk);
            check_all(int'(VECS[i].req), VECS[i].e_flag, VECS[i].e_prior,
                      VECS[i].e_snap, VECS[i].e_irqn);
        end
        capture = 1'b0; xact_active = 1'b0; stop_strobe = 1'b0;
        // R1: change in the capture clock is absorbed by the snapshot
        pin_in = 8'h55; xact_active = 1'b1; capture = 1'b1;
        @(negedge clk);
        capture = 1'b0;
        check_all(3, 8'h00, 8'h01, 8'h55, 1'b1);
        @(negedge clk);
        check_all(1, 8'h00, 8'h01, 8'h55, 1'b1);
        stop_strobe = 1'b1;
        @(negedge clk);
        stop_strobe = 1'b0; xact_active = 1'b0;
        check_all(6, 8'h00, 8'h01, 8'h55, 1'b1);
        // R2: several bits change together
        pin_in = 8'hAA;
        @(negedge clk);
        check_all(2, 8'hFF, 8'h01, 8'h55, 1'b0);
        // R10: reset mid-run clears everything
        rst_n = 1'b0;
        #1;
        check_all(10, 8'h00, 8'h00, 8'hFF, 1'b1);
        @(negedge clk);
        pin_in = 8'hFF;
        rst_n = 1'b1;
        @(negedge clk);
        check_all(10, 8'h00, 8'h00, 8'hFF, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule